// File: doc/BRIEF.md
# Sticky floating-point status flag register

This block keeps the accumulated status of a floating-point and SIMD execution unit. Every cycle the pipeline may raise pulses for six arithmetic exceptions, one pulse for integer saturation, and a four-bit comparison result. Control inputs supply one trap-enable bit per exception and a flush-to-zero mode bit. An exception whose trap is enabled is reported through the trap path, which lies outside this block, so it does not mark its flag here. Underflow is the single exception that still marks its flag under flush-to-zero, even when its trap is enabled.

Software reads the whole 64-bit value through a read port and replaces it through a write port. Exception and saturation flags are sticky: they stay set until software writes a 0 to them. The comparison nibble is loaded fresh on each update and is present only when the legacy comparison parameter is set. Every other bit reads as zero, and writes to those bits have no effect.

Top module: `fpstat_flags`

## Requirements
- R1: Once reset has been asserted, the read value is all zeros.
- R2: Bits 63:32 and every bit outside {31:27, 7, 4:0} always read 0, including after a write of all ones.
- R3: A flag at bit 27, 7, 4, 3, 2, 1 or 0 that has been set stays 1 in every following cycle without a write. Only a write carrying 0 in that bit clears it.
- R4: Exception input k (0 invalid, 1 divide-by-zero, 2 overflow, 4 inexact, 5 input-denormal) sets its flag at bit 0, 1, 2, 4 and 7 respectively only when trap_en[k] is 0. When trap_en[k] is 1 the pulse leaves the read value unchanged.
- R5: The underflow input exc_evt[3] sets bit 3 when trap_en[3] is 0 or ftz_en is 1. When trap_en[3] is 1 and ftz_en is 0 it has no effect.
- R6: A saturation pulse sets bit 27 whatever the trap enables and flush-to-zero mode are.
- R7: A write loads bits 27, 7 and 4:0 from wr_data, ORed with any flags set in the same cycle, so an event that coincides with a write is never lost.
- R8: With legacy comparison enabled, cmp_vld loads bits 31:28 from cmp_nzcv (bit 31 takes cmp_nzcv[3]) and replaces the old value. It wins over a write in the same cycle. Without either update, the bits hold.
- R9: With legacy comparison disabled, bits 31:28 read 0 whatever comparison updates or writes occur.
- R10: Each update becomes visible on rd_data after the rising edge that samples it, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exc_evt | input | 6 | Exception pulses: 0 invalid, 1 divide-by-zero, 2 overflow, 3 underflow, 4 inexact, 5 input-denormal |
| trap_en | input | 6 | Trap enable per exception, same order as exc_evt |
| ftz_en | input | 1 | Flush-to-zero mode |
| sat_evt | input | 1 | SIMD integer saturation pulse |
| cmp_vld | input | 1 | Comparison flag update strobe |
| cmp_nzcv | input | 4 | Comparison flags, bit 3 to register bit 31 |
| wr_en | input | 1 | Software write strobe |
| wr_data | input | 64 | Software write data |
| rd_data | output | 64 | Current register value |

## Verification
Every update, whether an event, a write or a comparison load, is captured by the one register stage. It therefore appears on rd_data one cycle after it is presented and never in the same cycle. The bench drives its inputs on the falling edge and advances its behavioural model at the rising edge that captures them. It compares outputs at the next falling edge, and for R10 it also samples just after driving to confirm that nothing has moved yet. Two instances run side by side, one with the legacy comparison nibble and one without, and both are checked against the model on every cycle of a randomized phase.

// File: rtl/fpstat_pkg.sv
package fpstat_pkg;

  localparam int NUM_EXC  = 6;
  localparam int LO_W     = 32;
  localparam int SAT_POS  = 27;
  localparam int CMP_LSB  = 28;
  localparam int CMP_W    = 4;
  localparam int UF_IDX   = 3;

  // Register bit that carries exception index k.
  function automatic int exc_pos(input int k);
    case (k)
      5:       return 7;
      default: return k;
    endcase
  endfunction

  // Exception events that may mark their flag.
  function automatic logic [NUM_EXC-1:0] gate_exc(
    input logic [NUM_EXC-1:0] evt,
    input logic [NUM_EXC-1:0] trap,
    input logic               ftz
  );
    logic [NUM_EXC-1:0] pass;
    pass = ~trap;
    pass[UF_IDX] = pass[UF_IDX] | ftz;
    return evt & pass;
  endfunction

  // Scatter per-exception bits into register positions.
  function automatic logic [LO_W-1:0] place_exc(input logic [NUM_EXC-1:0] v);
    logic [LO_W-1:0] r;
    r = '0;
    for (int k = 0; k < NUM_EXC; k++) r[exc_pos(k)] = v[k];
    return r;
  endfunction

  // Bits held by sticky flops.
  function automatic logic [LO_W-1:0] sticky_mask();
    logic [LO_W-1:0] r;
    r = place_exc('1);
    r[SAT_POS] = 1'b1;
    return r;
  endfunction

  // Bits that can read non-zero.
  function automatic logic [LO_W-1:0] visible_mask(input bit legacy);
    logic [LO_W-1:0] r;
    r = sticky_mask();
    if (legacy) r[CMP_LSB +: CMP_W] = '1;
    return r;
  endfunction

endpackage

// File: rtl/fpstat_gate.sv
module fpstat_gate
  import fpstat_pkg::*;
#(
  parameter int LW = 32
) (
  input  logic [NUM_EXC-1:0] exc_evt,
  input  logic [NUM_EXC-1:0] trap_en,
  input  logic               ftz_en,
  input  logic               sat_evt,
  output logic [LW-1:0]      set_vec
);

  logic [NUM_EXC-1:0] pass_evt;

  always_comb begin
    pass_evt = gate_exc(exc_evt, trap_en, ftz_en);
    set_vec = '0;
    set_vec[LO_W-1:0] = place_exc(pass_evt);
    set_vec[SAT_POS] = sat_evt;
  end

endmodule

// File: rtl/fpstat_sticky.sv
module fpstat_sticky #(
  parameter int              LW   = 32,
  parameter logic [LW-1:0]   MASK = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [LW-1:0] wr_data,
  input  logic [LW-1:0] set_vec,
  output logic [LW-1:0] q
);

  logic [LW-1:0] base;
  logic [LW-1:0] nxt;

  always_comb begin
    base = wr_en ? wr_data : q;
    nxt  = (base | set_vec) & MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= nxt;
  end

endmodule

// File: rtl/fpstat_cmp.sv
module fpstat_cmp
  import fpstat_pkg::*;
#(
  parameter bit LEGACY = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmp_vld,
  input  logic [CMP_W-1:0] cmp_nzcv,
  input  logic             wr_en,
  input  logic [CMP_W-1:0] wr_nzcv,
  output logic [CMP_W-1:0] q
);

  generate
    if (LEGACY) begin : g_live
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       q <= '0;
        else if (cmp_vld) q <= cmp_nzcv;
        else if (wr_en)   q <= wr_nzcv;
      end
    end else begin : g_tied
      logic unused_cmp;
      assign unused_cmp = ^{clk, rst_n, cmp_vld, cmp_nzcv, wr_en, wr_nzcv};
      assign q = '0;
    end
  endgenerate

endmodule

// File: rtl/fpstat_flags.sv
module fpstat_flags
  import fpstat_pkg::*;
#(
  parameter int REG_W      = 64,
  parameter bit LEGACY_CMP = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EXC-1:0] exc_evt,
  input  logic [NUM_EXC-1:0] trap_en,
  input  logic               ftz_en,
  input  logic               sat_evt,
  input  logic               cmp_vld,
  input  logic [CMP_W-1:0]   cmp_nzcv,
  input  logic               wr_en,
  input  logic [REG_W-1:0]   wr_data,
  output logic [REG_W-1:0]   rd_data
);

  localparam logic [LO_W-1:0] STK_MASK = sticky_mask();
  localparam int              HI_W     = REG_W - LO_W;

  logic [LO_W-1:0]  set_vec;
  logic [LO_W-1:0]  sticky_q;
  logic [CMP_W-1:0] cmp_q;
  logic [HI_W-1:0]  unused_hi;

  assign unused_hi = wr_data[REG_W-1:LO_W];

  fpstat_gate #(.LW(LO_W)) u_gate (
    .exc_evt (exc_evt),
    .trap_en (trap_en),
    .ftz_en  (ftz_en),
    .sat_evt (sat_evt),
    .set_vec (set_vec)
  );

  fpstat_sticky #(.LW(LO_W), .MASK(STK_MASK)) u_sticky (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data[LO_W-1:0]),
    .set_vec (set_vec),
    .q       (sticky_q)
  );

  fpstat_cmp #(.LEGACY(LEGACY_CMP)) u_cmp (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmp_vld  (cmp_vld),
    .cmp_nzcv (cmp_nzcv),
    .wr_en    (wr_en),
    .wr_nzcv  (wr_data[CMP_LSB +: CMP_W]),
    .q        (cmp_q)
  );

  always_comb begin
    rd_data = '0;
    rd_data[LO_W-1:0] = sticky_q;
    rd_data[CMP_LSB +: CMP_W] = cmp_q;
  end

endmodule

// File: rtl/fpstat_flags_chk.sv
module fpstat_flags_chk
  import fpstat_pkg::*;
#(
  parameter int REG_W      = 64,
  parameter bit LEGACY_CMP = 1'b1
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_EXC-1:0] exc_evt,
  input logic [NUM_EXC-1:0] trap_en,
  input logic               ftz_en,
  input logic               sat_evt,
  input logic               cmp_vld,
  input logic [CMP_W-1:0]   cmp_nzcv,
  input logic               wr_en,
  input logic [REG_W-1:0]   wr_data,
  input logic [LO_W-1:0]    set_vec,
  input logic [REG_W-1:0]   rd_data
);

  localparam logic [LO_W-1:0] STK = sticky_mask();
  localparam logic [LO_W-1:0] VIS = visible_mask(LEGACY_CMP);

  logic [LO_W-1:0] trapped_pos;
  assign trapped_pos = place_exc(trap_en & ~(NUM_EXC'(1) << UF_IDX));

  p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[REG_W-1:LO_W] == '0) && ((rd_data[LO_W-1:0] & ~VIS) == '0));

  p_sticky_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> (($past(rd_data[LO_W-1:0]) & STK & ~rd_data[LO_W-1:0]) == '0));

  p_trap_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ((rd_data[LO_W-1:0] & ~$past(rd_data[LO_W-1:0]) & $past(trapped_pos)) == '0));

  p_gate_subset_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec & trapped_pos) == '0);

  p_uf_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_evt[UF_IDX] && (ftz_en || !trap_en[UF_IDX])) |=> rd_data[exc_pos(UF_IDX)]);

  p_sat_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sat_evt |=> rd_data[SAT_POS]);

  p_write_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (($past(wr_data[LO_W-1:0]) & STK & ~rd_data[LO_W-1:0]) == '0));

  p_event_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(set_vec) & ~rd_data[LO_W-1:0]) == '0));

  generate
    if (LEGACY_CMP) begin : g_cmp
      p_cmp_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_vld |=> (rd_data[CMP_LSB +: CMP_W] == $past(cmp_nzcv)));
      p_cmp_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !cmp_vld) |=> (rd_data[CMP_LSB +: CMP_W] == $past(wr_data[CMP_LSB +: CMP_W])));
      p_cmp_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !cmp_vld) |=> $stable(rd_data[CMP_LSB +: CMP_W]));
    end else begin : g_nocmp
      p_cmp_absent_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[CMP_LSB +: CMP_W] == '0);
    end
  endgenerate

endmodule

bind fpstat_flags fpstat_flags_chk #(.REG_W(REG_W), .LEGACY_CMP(LEGACY_CMP)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .exc_evt  (exc_evt),
  .trap_en  (trap_en),
  .ftz_en   (ftz_en),
  .sat_evt  (sat_evt),
  .cmp_vld  (cmp_vld),
  .cmp_nzcv (cmp_nzcv),
  .wr_en    (wr_en),
  .wr_data  (wr_data),
  .set_vec  (set_vec),
  .rd_data  (rd_data)
);

// File: tb/fpstat_flags_bench.sv
module fpstat_flags_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  exc_evt = '0;
  logic [5:0]  trap_en = '0;
  logic        ftz_en = 1'b0;
  logic        sat_evt = 1'b0;
  logic        cmp_vld = 1'b0;
  logic [3:0]  cmp_nzcv = '0;
  logic        wr_en = 1'b0;
  logic [63:0] wr_data = '0;
  logic [63:0] rd_leg;
  logic [63:0] rd_pln;

  logic [63:0] m_leg;
  logic [63:0] m_pln;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  fpstat_flags u_fpstat_flags (
    .clk(clk), .rst_n(rst_n), .exc_evt(exc_evt), .trap_en(trap_en),
    .ftz_en(ftz_en), .sat_evt(sat_evt), .cmp_vld(cmp_vld),
    .cmp_nzcv(cmp_nzcv), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_leg)
  );

  fpstat_flags #(.LEGACY_CMP(1'b0)) u_fpstat_flags_plain (
    .clk(clk), .rst_n(rst_n), .exc_evt(exc_evt), .trap_en(trap_en),
    .ftz_en(ftz_en), .sat_evt(sat_evt), .cmp_vld(cmp_vld),
    .cmp_nzcv(cmp_nzcv), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_pln)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Behavioural reference: one flag at a time, written from the requirements.
  function automatic logic [63:0] ref_step(input bit legacy, input logic [63:0] cur);
    logic [63:0] n;
    int where;
    n = 64'h0;
    for (int k = 0; k < 6; k++) begin
      where = (k == 5) ? 7 : k;
      if (wr_en) n[where] = wr_data[where];
      else       n[where] = cur[where];
      if (exc_evt[k]) begin
        if (trap_en[k] == 1'b0) n[where] = 1'b1;
        else if (k == 3 && ftz_en) n[where] = 1'b1;
      end
    end
    n[27] = sat_evt ? 1'b1 : (wr_en ? wr_data[27] : cur[27]);
    if (legacy) begin
      if (cmp_vld)    n[31:28] = cmp_nzcv;
      else if (wr_en) n[31:28] = wr_data[31:28];
      else            n[31:28] = cur[31:28];
    end
    return n;
  endfunction

  function automatic string tag_of(input logic [63:0] diff);
    if (diff[63:32] != 0 || diff[26:8] != 0 || diff[6:5] != 0) return "R2";
    if (diff[31:28] != 0) return "R8";
    return "R3";
  endfunction

  // Called just after a falling edge; inputs are already driven.
  task automatic cyc();
    @(posedge clk);
    m_leg = ref_step(1'b1, m_leg);
    m_pln = ref_step(1'b0, m_pln);
    @(negedge clk);
  endtask

  task automatic idle_inputs();
    exc_evt = '0; sat_evt = 0; cmp_vld = 0; wr_en = 0; wr_data = '0;
    cmp_nzcv = '0;
  endtask

  initial begin
    #1600000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    m_leg = '0; m_pln = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1 reset legacy", rd_leg, 64'h0);
    check("R1 reset plain", rd_pln, 64'h0);

    // R6 saturation with all traps enabled
    trap_en = 6'h3F; sat_evt = 1;
    #1;
    check("R10 no change before edge", rd_leg, 64'h0);
    cyc(); idle_inputs();
    check("R6 saturation", rd_leg, 64'h0800_0000);

    // R4 trapped events have no effect
    exc_evt = 6'b110111; trap_en = 6'h3F; ftz_en = 0;
    cyc(); idle_inputs();
    check("R4 trapped ignored", rd_leg, 64'h0800_0000);

    // R4 untrapped events
    trap_en = 6'h00; exc_evt = 6'b010111;
    cyc(); idle_inputs();
    check("R4 untrapped set", rd_leg, 64'h0800_0017);

    // R5 underflow under flush-to-zero with trap enabled
    trap_en = 6'h3F; ftz_en = 1; exc_evt = 6'b001000;
    cyc(); idle_inputs(); ftz_en = 0;
    check("R5 ftz underflow", rd_leg, 64'h0800_001F);

    // R7 write of zero clears
    wr_en = 1; wr_data = 64'h0;
    cyc(); idle_inputs();
    check("R7 write clears", rd_leg, 64'h0);

    // R5 trapped underflow without ftz ignored, then untrapped
    trap_en = 6'b001000; exc_evt = 6'b001000;
    cyc(); idle_inputs();
    check("R5 trapped underflow", rd_leg, 64'h0);
    trap_en = 6'b000000; exc_evt = 6'b001000;
    cyc(); idle_inputs();
    check("R5 untrapped underflow", rd_leg, 64'h8);

    // R3 holds over idle cycles
    repeat (5) cyc();
    check("R3 sticky hold", rd_leg, 64'h8);

    // R2 write of all ones
    wr_en = 1; wr_data = '1;
    cyc(); idle_inputs();
    check("R2 reserved legacy", rd_leg, 64'hF800_009F);
    check("R9 reserved plain", rd_pln, 64'h0800_009F);

    // R7 write and event in the same cycle
    wr_en = 1; wr_data = 64'h0; exc_evt = 6'b000001; trap_en = 6'h00;
    cyc(); idle_inputs();
    check("R7 write plus event", rd_leg, 64'h1);

    // R8 comparison wins over write
    wr_en = 1; wr_data = 64'hF000_0000; cmp_vld = 1; cmp_nzcv = 4'b1010;
    cyc(); idle_inputs();
    check("R8 cmp over write", rd_leg, 64'hA000_0000);
    check("R9 plain no cmp", rd_pln, 64'h0);

    // R8 comparison replaces, not sticky
    cmp_vld = 1; cmp_nzcv = 4'b0101;
    cyc(); idle_inputs();
    check("R8 cmp replace", rd_leg, 64'h5000_0000);

    // R4 input-denormal lands on bit 7
    exc_evt = 6'b100000;
    cyc(); idle_inputs();
    check("R4 input denormal", rd_leg, 64'h5000_0080);
    check("R8 cmp hold", rd_leg[31:28], 64'h5);

    // Randomized phase against the model
    for (int i = 0; i < 3000; i++) begin
      exc_evt  = 6'($urandom) & 6'($urandom);
      trap_en  = 6'($urandom);
      ftz_en   = 1'($urandom);
      sat_evt  = ($urandom % 8) == 0;
      cmp_vld  = ($urandom % 4) == 0;
      cmp_nzcv = 4'($urandom);
      wr_en    = ($urandom % 8) == 0;
      wr_data  = {$urandom, $urandom};
      cyc();
      check({tag_of(rd_leg ^ m_leg), " random legacy"}, rd_leg, m_leg);
      check({tag_of(rd_pln ^ m_pln), " random plain"}, rd_pln, m_pln);
    end
    idle_inputs();

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule